// File: doc/BRIEF.md
# Password-Guarded Control Register Unlock

This block holds a small watchdog control register and makes every change to it a two-step bus operation. The first write is an unlock request. It must carry a fixed key nibble, the user password that is currently stored, and an opening guard code. If all three match, a short modify window opens. A second write inside that window must carry a commit guard code. When it does, it loads new values into every field: the reload value, the user password, the prescaler select, the watchdog-off bit and the end-of-initialization bit. It also pulses a service strobe to the watchdog counter.

Any mismatch gives a one-cycle access-error strobe, which the watchdog counter turns into a reset. This covers a bad key, a stale password, a wrong guard code on either step, or a second write whose guard is wrong. If no second write arrives in time, the window closes. A write after the window has closed is judged as a new unlock request.

The end-of-initialization bit is driven out continuously as a write-protect line for other critical registers. Password checking and the protect line stay active when the watchdog-off bit is set.

Top module: `ctl_unlock`

## Requirements
- R1: After reset, end_init_o, reload_o, presc_sel_o, wd_off_o, access_err_o and service_o are all 0, and the stored user password equals the RESET_PW parameter (default 8'h00).
- R2: With no window open, a write opens the window when wr_data[7:4]=4'hF, wr_data[15:8] equals the stored password, and wr_data[1:0]=2'b01. Such a write raises no strobe and changes no field.
- R3: With no window open, a write that fails any part of the R2 check raises access_err_o for one cycle, starting one clock after the write edge. It changes no field and leaves the window closed.
- R4: A write inside the window with wr_data[1:0]=2'b10 loads the following fields, and raises service_o for one cycle starting one clock after the write edge:
  - wr_data[31:16] into reload_o
  - wr_data[15:8] into the stored password
  - wr_data[4] into presc_sel_o
  - wr_data[3] into wd_off_o
  - wr_data[2] into end_init_o
- R5: A write inside the window whose wr_data[1:0] is not 2'b10 raises access_err_o, changes no field and closes the window. The window also closes after any commit.
- R6: The window accepts a second write up to WINDOW clock edges after the opening write's edge (default 16). A write at a later edge is judged under R2/R3 as a new first write.
- R7: end_init_o always shows the stored end-of-initialization bit. The R2/R3 checks still apply while wd_off_o is 1.
- R8: access_err_o and service_o are never high together, and each is high only in the cycle after a write edge.
- R9: After a commit, only the newly stored password opens the window. The previous password gives an access error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 32 | Write data: guard, end-init, off, key/prescaler, password and reload fields |
| end_init_o | output | 1 | End-of-initialization bit, used as a write-protect line |
| reload_o | output | 16 | Stored watchdog reload value |
| presc_sel_o | output | 1 | Stored prescaler select |
| wd_off_o | output | 1 | Stored watchdog-off bit |
| access_err_o | output | 1 | One-cycle access error strobe to the watchdog counter |
| service_o | output | 1 | One-cycle service strobe after a successful commit |

## Verification
The assertions take for granted that reset is held for at least two clocks, and only once, before traffic starts. They also assume that wr_data is read only in cycles where wr_en is high, so a strobe can always be traced to the write edge just before it. The stimulus keeps within these assumptions. It holds reset for several cycles at start-up and never asserts it again. It changes wr_en and wr_data only on falling clock edges, and each write lasts exactly one cycle. The write patterns are chosen to reach the window's last accepted edge and its first rejected edge.

// File: rtl/ctl_unlock_pkg.sv
package ctl_unlock_pkg;

    localparam int WORD_W = 32;
    localparam int RLD_W  = 16;
    localparam int PW_W   = 8;
    localparam int KEY_W  = 4;

    localparam logic [KEY_W-1:0] FIXED_KEY    = 4'hF;
    localparam logic [1:0]       GUARD_OPEN   = 2'b01;
    localparam logic [1:0]       GUARD_COMMIT = 2'b10;

    // bus word layout, MSB first
    typedef struct packed {
        logic [RLD_W-1:0] reload;
        logic [PW_W-1:0]  pw;
        logic [KEY_W-1:0] key;     // fixed key on open, bit 0 = prescaler on commit
        logic             off;
        logic             eoi;
        logic [1:0]       guard;
    } ctl_word_t;

    typedef struct packed {
        logic [RLD_W-1:0] reload;
        logic [PW_W-1:0]  pw;
        logic             presc;
        logic             off;
        logic             eoi;
    } ctl_state_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_OPEN,
        WK_COMMIT,
        WK_FAULT
    } wr_kind_e;

    function automatic logic open_ok(ctl_word_t w, logic [PW_W-1:0] cur);
        return (w.key == FIXED_KEY) && (w.pw == cur) && (w.guard == GUARD_OPEN);
    endfunction

    function automatic logic commit_ok(ctl_word_t w);
        return w.guard == GUARD_COMMIT;
    endfunction

    function automatic ctl_state_t take_fields(ctl_word_t w);
        ctl_state_t s;
        s.reload = w.reload;
        s.pw     = w.pw;
        s.presc  = w.key[0];
        s.off    = w.off;
        s.eoi    = w.eoi;
        return s;
    endfunction

    function automatic ctl_state_t reset_state(logic [PW_W-1:0] pw0);
        ctl_state_t s;
        s        = '0;
        s.pw     = pw0;
        return s;
    endfunction

endpackage

// File: rtl/ctl_unlock_classify.sv
module ctl_unlock_classify
    import ctl_unlock_pkg::*;
(
    input  logic                wr_en,
    input  ctl_word_t           word,
    input  logic                win_open,
    input  logic [PW_W-1:0]     cur_pw,
    output wr_kind_e            kind
);
    always_comb begin
        kind = WK_IDLE;
        if (wr_en) begin
            if (win_open) begin
                kind = commit_ok(word) ? WK_COMMIT : WK_FAULT;
            end else begin
                kind = open_ok(word, cur_pw) ? WK_OPEN : WK_FAULT;
            end
        end
    end
endmodule

// File: rtl/ctl_unlock_window.sv
module ctl_unlock_window #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic close,
    output logic open
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (close) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= CW'(WINDOW);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign open = (cnt != '0);
endmodule

// File: rtl/ctl_unlock_fields.sv
module ctl_unlock_fields
    import ctl_unlock_pkg::*;
#(
    parameter logic [PW_W-1:0] RESET_PW = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  ctl_word_t  word,
    output ctl_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= reset_state(RESET_PW);
        end else if (load) begin
            state <= take_fields(word);
        end
    end
endmodule

// File: rtl/ctl_unlock.sv
module ctl_unlock
    import ctl_unlock_pkg::*;
#(
    parameter int              WINDOW   = 16,
    parameter logic [PW_W-1:0] RESET_PW = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              end_init_o,
    output logic [RLD_W-1:0]  reload_o,
    output logic              presc_sel_o,
    output logic              wd_off_o,
    output logic              access_err_o,
    output logic              service_o
);
    ctl_word_t  word;
    ctl_state_t state;
    wr_kind_e   kind;
    logic       win_open;
    logic [PW_W-1:0] cur_pw;
    logic       err_q;
    logic       svc_q;

    assign word   = ctl_word_t'(wr_data);
    assign cur_pw = state.pw;

    ctl_unlock_classify u_classify (
        .wr_en    (wr_en),
        .word     (word),
        .win_open (win_open),
        .cur_pw   (cur_pw),
        .kind     (kind)
    );

    ctl_unlock_window #(.WINDOW(WINDOW)) u_window (
        .clk   (clk),
        .rst   (rst),
        .arm   (kind == WK_OPEN),
        .close ((kind == WK_COMMIT) || (kind == WK_FAULT)),
        .open  (win_open)
    );

    ctl_unlock_fields #(.RESET_PW(RESET_PW)) u_fields (
        .clk   (clk),
        .rst   (rst),
        .load  (kind == WK_COMMIT),
        .word  (word),
        .state (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            svc_q <= 1'b0;
        end else begin
            err_q <= (kind == WK_FAULT);
            svc_q <= (kind == WK_COMMIT);
        end
    end

    assign end_init_o   = state.eoi;
    assign reload_o     = state.reload;
    assign presc_sel_o  = state.presc;
    assign wd_off_o     = state.off;
    assign access_err_o = err_q;
    assign service_o    = svc_q;
endmodule

// File: rtl/ctl_unlock_chk.sv
module ctl_unlock_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_lo,
    input logic        win_open,
    input logic [7:0]  cur_pw,
    input logic        end_init_o,
    input logic [15:0] reload_o,
    input logic        presc_sel_o,
    input logic        wd_off_o,
    input logic        access_err_o,
    input logic        service_o
);
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(access_err_o && service_o));

    assert_err_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        access_err_o |-> $past(wr_en));

    assert_svc_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        service_o |-> $past(wr_en && win_open));

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !win_open && (wr_lo[7:4] != 4'hF)) |=> access_err_o);

    assert_good_open_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !win_open && (wr_lo[7:4] == 4'hF) && (wr_lo[15:8] == cur_pw)
         && (wr_lo[1:0] == 2'b01)) |=> (win_open && !access_err_o && !service_o));

    assert_hold_fields_R5: assert property (@(posedge clk) disable iff (rst)
        (!service_o && !$past(rst)) |->
            $stable({end_init_o, reload_o, presc_sel_o, wd_off_o}));
endmodule

bind ctl_unlock ctl_unlock_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_lo        (wr_data[15:0]),
    .win_open     (win_open),
    .cur_pw       (cur_pw),
    .end_init_o   (end_init_o),
    .reload_o     (reload_o),
    .presc_sel_o  (presc_sel_o),
    .wd_off_o     (wd_off_o),
    .access_err_o (access_err_o),
    .service_o    (service_o)
);

// File: tb/ctl_unlock_bench.sv
`timescale 1ns/1ps
module ctl_unlock_bench;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        end_init_o, presc_sel_o, wd_off_o, access_err_o, service_o;
    logic [15:0] reload_o;

    ctl_unlock u_ctl_unlock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .end_init_o(end_init_o), .reload_o(reload_o), .presc_sel_o(presc_sel_o),
        .wd_off_o(wd_off_o), .access_err_o(access_err_o), .service_o(service_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          due;
        logic        err, svc, eoi, presc, off;
        logic [15:0] reload;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   fails = 0;
    bit   done = 0;

    // reference model state
    logic [7:0]  m_pw = 8'h00;
    logic [15:0] m_reload = '0;
    logic        m_presc = 0, m_off = 0, m_eoi = 0;
    bit          m_armed = 0;
    int          m_arm_edge = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(logic [15:0] rl, logic [7:0] pw, logic [3:0] key,
                                       logic off, logic eoi, logic [1:0] g);
        return {rl, pw, key, off, eoi, g};
    endfunction

    task automatic check(string tag, logic err, logic svc, logic eoi, logic [15:0] rl,
                         logic presc, logic off);
        total++;
        if (access_err_o !== err || service_o !== svc || end_init_o !== eoi ||
            reload_o !== rl || presc_sel_o !== presc || wd_off_o !== off) begin
            fails++;
            $display("FAIL %s: got err=%0b svc=%0b eoi=%0b rld=%h ps=%0b off=%0b exp err=%0b svc=%0b eoi=%0b rld=%h ps=%0b off=%0b",
                     tag, access_err_o, service_o, end_init_o, reload_o, presc_sel_o, wd_off_o,
                     err, svc, eoi, rl, presc, off);
        end
    endtask

    // driver: computes expectation from the requirements and pushes it
    task automatic bus_write(logic [31:0] w, string tag);
        exp_t e;
        int   edge_no;
        bit   in_win;
        @(negedge clk);
        edge_no = cyc + 1;
        in_win  = m_armed && ((edge_no - m_arm_edge) <= WIN);
        e.err = 0;
        e.svc = 0;
        if (in_win) begin
            m_armed = 0;
            if (w[1:0] == 2'b10) begin
                e.svc    = 1;
                m_reload = w[31:16];
                m_pw     = w[15:8];
                m_presc  = w[4];
                m_off    = w[3];
                m_eoi    = w[2];
            end else begin
                e.err = 1;
            end
        end else if (w[7:4] == 4'hF && w[15:8] == m_pw && w[1:0] == 2'b01) begin
            m_armed    = 1;
            m_arm_edge = edge_no;
        end else begin
            m_armed = 0;
            e.err   = 1;
        end
        e.due    = edge_no;
        e.eoi    = m_eoi;
        e.presc  = m_presc;
        e.off    = m_off;
        e.reload = m_reload;
        e.tag    = tag;
        q.push_back(e);
        wr_en   = 1'b1;
        wr_data = w;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, e.err, e.svc, e.eoi, e.reload, e.presc, e.off);
            end else if (access_err_o || service_o) begin
                check("R8 stray strobe", 1'b0, 1'b0, m_eoi, m_reload, m_presc, m_off);
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 0, 0, 0, 16'h0000, 0, 0);

        bus_write(mk(16'h0, 8'h00, 4'hF, 0, 0, 2'b01), "R2 open with reset password");
        idle(2);
        bus_write(mk(16'h1234, 8'h5A, 4'h1, 0, 1, 2'b10), "R4 commit fields, R7 end-init set");
        idle(2);
        bus_write(mk(16'h0, 8'h5A, 4'hE, 0, 0, 2'b01), "R3 wrong fixed key");
        idle(1);
        bus_write(mk(16'h0, 8'h00, 4'hF, 0, 0, 2'b01), "R9 stale password");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b11), "R3 bad opening guard");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R9 open with new password");
        bus_write(mk(16'hFFFF, 8'h5A, 4'h0, 1, 0, 2'b11), "R5 bad commit guard");
        idle(1);
        bus_write(mk(16'hBEEF, 8'h5A, 4'h0, 0, 0, 2'b10), "R5 commit word with window closed");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R2 open before edge test");
        idle(WIN - 1);
        bus_write(mk(16'h00FF, 8'h5A, 4'h0, 0, 1, 2'b10), "R6 commit on last window edge");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R2 open before late test");
        idle(WIN);
        bus_write(mk(16'h0F0F, 8'h5A, 4'h0, 0, 1, 2'b10), "R6 commit one edge late");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R2 open then let it lapse");
        idle(20);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R6 late write judged as first write");
        bus_write(mk(16'hA5A5, 8'h3C, 4'h1, 1, 1, 2'b10), "R4 commit with watchdog off");
        idle(1);
        bus_write(mk(16'h0, 8'h5A, 4'hF, 0, 0, 2'b01), "R7 bad password while off");
        idle(1);
        bus_write(mk(16'h0, 8'h3C, 4'hF, 0, 0, 2'b01), "R2 open while off");
        bus_write(mk(16'h0, 8'h3C, 4'hF, 0, 0, 2'b01), "R5 opening word inside window");
        idle(1);
        bus_write(mk(16'h0, 8'h3C, 4'hF, 0, 0, 2'b01), "R2 open for clear");
        bus_write(mk(16'h0000, 8'h3C, 4'h0, 0, 0, 2'b10), "R7 end-init cleared");
        idle(3);
        if (q.size() != 0) begin
            total++;
            fails++;
            $display("FAIL R8 missing results: got %0d pending expected 0", q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule